// File: doc/BRIEF.md
# Byte Program-and-Verify Retry Sequencer

This block drives a byte-wide one-time-programmable memory through a fast programming algorithm. On a start request it raises the elevated core supply and the programming voltage, then walks an address range from a start address to an end address. For every address it fetches the intended byte from a byte buffer over a request/acknowledge port. It then applies program strobe pulses of a fixed clock-counted width and reads the byte back after each pulse. Pulses are repeated until the read-back byte matches or a per-byte pulse limit is reached.

When the last address has been programmed, both supplies return to their normal level. Every byte in the range is then fetched again and read back without any pulse. The run ends with pass asserted, or with fail asserted together with the failing address and a flag telling whether the failure came from programming or from the final read-back. Supply control is represented by two enable outputs only. With the default 17-bit address width the whole range from 0x00000 to 0x1FFFF can be covered.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, pass, fail, src_req, vcc_hi_en and vpp_hi_en are 0, and mem_ce_n, mem_oe_n and mem_pgm_n are 1.
- R2: An accepted start raises vcc_hi_en and vpp_hi_en at least RAMP_CYC cycles before the first program pulse, and both are 1 during every pulse.
- R3: Each program pulse holds mem_pgm_n at 0 for exactly PULSE_CYC cycles, with mem_ce_n at 0 and mem_oe_n at 1. mem_addr and mem_wdata are unchanged from one cycle before the falling edge until one cycle after the rising edge.
- R4: After every pulse the byte is read with mem_oe_n at 0 for READ_CYC cycles, and mem_rdata is compared with the byte fetched for that address.
- R5: On a mismatch another pulse is applied, and one address never receives more than MAX_TRY pulses (default 25).
- R6: A byte still wrong after MAX_TRY pulses ends the run: fail becomes 1, fail_addr holds that address, fail_phase is 0, busy falls and both supply enables fall.
- R7: On a match the sequencer moves to the next address and the pulse count restarts at zero, so each byte has its own MAX_TRY allowance.
- R8: After the end address both supply enables fall. Every byte of the range is then fetched again and read back once, with no program pulse.
- R9: A mismatch in the read-back pass sets fail, sets fail_phase to 1, and sets fail_addr to the first mismatching address.
- R10: If every byte matches in the read-back pass, pass becomes 1 and busy falls. pass and fail hold until the next accepted start, which clears both.
- R11: A start while busy is ignored: the latched range and the running sequence are unchanged.
- R12: A byte is requested by holding src_req at 1 with src_addr until src_ack is seen. src_data is taken in that cycle, and exactly one fetch is made per address in each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only when idle |
| start_addr | input | AW | First address of the range |
| end_addr | input | AW | Last address of the range |
| src_req | output | 1 | Byte fetch request to the buffer |
| src_addr | output | AW | Address of the requested byte |
| src_ack | input | 1 | Buffer acknowledge, src_data valid |
| src_data | input | DW | Intended byte |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data presented for programming |
| mem_rdata | input | DW | Data read from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vcc_hi_en | output | 1 | Elevated core supply enable |
| vpp_hi_en | output | 1 | Programming voltage enable |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run passed |
| fail | output | 1 | Last run failed |
| fail_addr | output | AW | Address that failed |
| fail_phase | output | 1 | 0 = program pass, 1 = read-back pass |

## Verification
The bench builds the block with AW=8, PULSE_CYC=6, READ_CYC=2, RAMP_CYC=3 and the real MAX_TRY of 25. The short pulse and ramp keep a byte that needs all 25 pulses to only a few hundred cycles. This lets the exact retry limit, a byte one pulse beyond it, and two stubborn neighbours in a row all be exercised. The 8-bit range makes the top address 0xFF and single-byte ranges cheap to reach.

// File: rtl/otp_prog_seq_pkg.sv
package otp_prog_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAMP_UP,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_READ,
    ST_RAMP_DN,
    ST_VFETCH,
    ST_VREAD
  } seq_state_e;

  localparam logic PHASE_PROGRAM = 1'b0;
  localparam logic PHASE_VERIFY  = 1'b1;
endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                count_q <= '0;
    else if (load)          count_q <= load_val;
    else if (count_q != '0) count_q <= count_q - 1'b1;
  end

  assign zero = (count_q == '0);
endmodule

// File: rtl/otp_addr_walker.sv
module otp_addr_walker #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= addr + 1'b1;
  end

  assign at_last = (addr == last_addr);
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX_TRY = 25,
  localparam int CW = $clog2(MAX_TRY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          bump,
  output logic [CW-1:0] tries,
  output logic          at_limit
);
  always_ff @(posedge clk) begin
    if (rst || clear)           tries <= '0;
    else if (bump && !at_limit) tries <= tries + 1'b1;
  end

  assign at_limit = (tries == CW'(MAX_TRY));

  // R5: a byte never sees more pulses than the limit
  a_r5_try_bound: assert property (@(posedge clk) disable iff (rst)
    tries <= CW'(MAX_TRY));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_seq_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int PULSE_CYC = 5000,
  parameter int READ_CYC  = 4,
  parameter int RAMP_CYC  = 64,
  parameter int MAX_TRY   = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          src_req,
  output logic [AW-1:0] src_addr,
  input  logic          src_ack,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic          vcc_hi_en,
  output logic          vpp_hi_en,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          fail_phase
);
  localparam int MAX_PR = (PULSE_CYC > RAMP_CYC) ? PULSE_CYC : RAMP_CYC;
  localparam int MAX_C  = (MAX_PR > READ_CYC) ? MAX_PR : READ_CYC;
  localparam int TW     = $clog2(MAX_C + 1);
  localparam int CW     = $clog2(MAX_TRY + 1);

  seq_state_e    state_q, state_n;
  logic [AW-1:0] start_q, end_q, addr;
  logic [DW-1:0] data_q;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          w_load, w_step, at_last;
  logic          try_clr, try_bump, at_limit;
  logic [CW-1:0] tries;
  logic          accept, data_ld, done_pass, done_fail, fail_ph_n, match;

  otp_cycle_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  otp_addr_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst(rst), .load(w_load),
    .load_addr((state_q == ST_IDLE) ? start_addr : start_q),
    .step(w_step), .last_addr(end_q), .addr(addr), .at_last(at_last)
  );

  otp_try_counter #(.MAX_TRY(MAX_TRY)) u_tries (
    .clk(clk), .rst(rst), .clear(try_clr), .bump(try_bump),
    .tries(tries), .at_limit(at_limit)
  );

  assign match = (mem_rdata == data_q);

  always_comb begin
    state_n   = state_q;
    t_load    = 1'b0;
    t_val     = '0;
    w_load    = 1'b0;
    w_step    = 1'b0;
    try_clr   = 1'b0;
    try_bump  = 1'b0;
    accept    = 1'b0;
    data_ld   = 1'b0;
    done_pass = 1'b0;
    done_fail = 1'b0;
    fail_ph_n = PHASE_PROGRAM;
    unique case (state_q)
      ST_IDLE: if (start) begin
        accept  = 1'b1;
        w_load  = 1'b1;
        try_clr = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(RAMP_CYC - 1);
        state_n = ST_RAMP_UP;
      end
      ST_RAMP_UP: if (t_zero) state_n = ST_FETCH;
      ST_FETCH: if (src_ack && src_req) begin
        data_ld = 1'b1;
        state_n = ST_SETUP;
      end
      ST_SETUP: begin
        t_load   = 1'b1;
        t_val    = TW'(PULSE_CYC - 1);
        try_bump = 1'b1;
        state_n  = ST_PULSE;
      end
      ST_PULSE: if (t_zero) state_n = ST_HOLD;
      ST_HOLD: begin
        t_load  = 1'b1;
        t_val   = TW'(READ_CYC - 1);
        state_n = ST_READ;
      end
      ST_READ: if (t_zero) begin
        if (match && at_last) begin
          w_load  = 1'b1;
          t_load  = 1'b1;
          t_val   = TW'(RAMP_CYC - 1);
          state_n = ST_RAMP_DN;
        end else if (match) begin
          w_step  = 1'b1;
          try_clr = 1'b1;
          state_n = ST_FETCH;
        end else if (at_limit) begin
          done_fail = 1'b1;
          state_n   = ST_IDLE;
        end else begin
          state_n = ST_SETUP;
        end
      end
      ST_RAMP_DN: if (t_zero) state_n = ST_VFETCH;
      ST_VFETCH: if (src_ack && src_req) begin
        data_ld = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(READ_CYC - 1);
        state_n = ST_VREAD;
      end
      ST_VREAD: if (t_zero) begin
        if (!match) begin
          done_fail = 1'b1;
          fail_ph_n = PHASE_VERIFY;
          state_n   = ST_IDLE;
        end else if (at_last) begin
          done_pass = 1'b1;
          state_n   = ST_IDLE;
        end else begin
          w_step  = 1'b1;
          state_n = ST_VFETCH;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      start_q    <= '0;
      end_q      <= '0;
      data_q     <= '0;
      mem_pgm_n  <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_ce_n   <= 1'b1;
      vcc_hi_en  <= 1'b0;
      vpp_hi_en  <= 1'b0;
      src_req    <= 1'b0;
      busy       <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      fail_addr  <= '0;
      fail_phase <= PHASE_PROGRAM;
    end else begin
      state_q   <= state_n;
      mem_pgm_n <= (state_n != ST_PULSE);
      mem_oe_n  <= !(state_n == ST_READ || state_n == ST_VREAD);
      mem_ce_n  <= (state_n == ST_IDLE);
      vcc_hi_en <= state_n inside {ST_RAMP_UP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD, ST_READ};
      vpp_hi_en <= state_n inside {ST_RAMP_UP, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD, ST_READ};
      src_req   <= (state_n == ST_FETCH) || (state_n == ST_VFETCH);
      busy      <= (state_n != ST_IDLE);
      if (data_ld) data_q <= src_data;
      if (accept) begin
        start_q <= start_addr;
        end_q   <= end_addr;
        pass    <= 1'b0;
        fail    <= 1'b0;
      end
      if (done_pass) pass <= 1'b1;
      if (done_fail) begin
        fail       <= 1'b1;
        fail_addr  <= addr;
        fail_phase <= fail_ph_n;
      end
    end
  end

  assign src_addr  = addr;
  assign mem_addr  = addr;
  assign mem_wdata = data_q;

  // Checker state: length of the current low run of the program strobe
  logic [31:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || mem_pgm_n) low_run <= '0;
    else                  low_run <= low_run + 1;
  end

  // R1: nothing is driven toward the memory while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_pgm_n && !vpp_hi_en && !vcc_hi_en && !src_req));
  // R2: supplies are up whenever a pulse is applied
  a_r2_supply_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !mem_pgm_n |-> (vpp_hi_en && vcc_hi_en));
  // R3: strobe framing during a pulse
  a_r3_pulse_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_pgm_n |-> (!mem_ce_n && mem_oe_n));
  // R3: address and data held through the pulse and one cycle after
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_pgm_n || $rose(mem_pgm_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
  // R3: pulse width in clock cycles
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_pgm_n) |-> (low_run == 32'(PULSE_CYC)));
  // R8: read-back pass runs at normal supply with no pulse
  a_r8_verify_normal: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VREAD) |-> (!vpp_hi_en && !vcc_hi_en && mem_pgm_n));
  // R10: pass and fail are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));
  // R6: a failure leaves the supplies off and the block idle
  a_r6_fail_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (!busy && !vpp_hi_en));
  // R11: latched range does not move during a run
  a_r11_range_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(end_q) && $stable(start_q)));
endmodule

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PULSE = 6;
  localparam int READC = 2;
  localparam int RAMP = 3;
  localparam int MAXT = 25;

  logic clk = 0, rst = 1, start = 0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic src_req, src_ack = 0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data = '0, mem_wdata, mem_rdata;
  logic mem_ce_n, mem_oe_n, mem_pgm_n, vcc_hi_en, vpp_hi_en;
  logic busy, pass, fail, fail_phase;

  logic [7:0] mem [256];
  logic [7:0] drift [256];
  logic [7:0] srcb [256];
  int need [256];
  int cnt [256];

  int total = 0, bad = 0;
  int vpp_cnt = 0, run_pulses = 0, run_acks = 0, low_run = 0, dly = 0;
  int cur_s = 0, cur_e = 0;
  bit first_pulse = 1, read_seen = 0, prev_pgm = 1;
  logic [AW-1:0] prev_addr = '0, pulse_addr = '0;
  logic [DW-1:0] prev_wd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .READ_CYC(READC),
                 .RAMP_CYC(RAMP), .MAX_TRY(MAXT)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
    .vcc_hi_en(vcc_hi_en), .vpp_hi_en(vpp_hi_en), .busy(busy), .pass(pass),
    .fail(fail), .fail_addr(fail_addr), .fail_phase(fail_phase)
  );

  // memory model: reads show drift only at normal supply
  assign mem_rdata = mem_oe_n ? 8'h00 : (mem[mem_addr] ^ (vpp_hi_en ? 8'h00 : drift[mem_addr]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse monitor, memory cell model and byte buffer
  always @(negedge clk) begin
    if (!rst) begin
      if (vpp_hi_en && mem_pgm_n) vpp_cnt++;
      if (!mem_oe_n) read_seen = 1;
      if (!mem_pgm_n) begin
        if (prev_pgm) begin
          chk(mem_addr == prev_addr && mem_wdata == prev_wd, "R3 setup before fall", mem_addr, prev_addr);
          chk(vpp_hi_en && vcc_hi_en, "R2 supplies during pulse", vpp_hi_en, 1);
          if (first_pulse) chk(vpp_cnt >= RAMP, "R2 ramp before first pulse", vpp_cnt, RAMP);
          else chk(read_seen, "R4 read-back between pulses", read_seen, 1);
          first_pulse = 0; read_seen = 0; low_run = 0; pulse_addr = mem_addr;
        end
        low_run++;
        chk(!mem_ce_n && mem_oe_n, "R3 strobes during pulse", {mem_ce_n, mem_oe_n}, 1);
      end else if (!prev_pgm) begin
        chk(low_run == PULSE, "R3 pulse width", low_run, PULSE);
        chk(mem_addr == pulse_addr && mem_wdata == prev_wd, "R3 hold after rise", mem_addr, pulse_addr);
        cnt[mem_addr]++;
        run_pulses++;
        if (cnt[mem_addr] >= need[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_wdata;
        read_seen = 0;
      end
      prev_pgm = mem_pgm_n; prev_addr = mem_addr; prev_wd = mem_wdata;
      if (src_ack) src_ack = 0;
      else if (src_req) begin
        if (dly == 0) begin
          src_data = srcb[src_addr];
          src_ack = 1;
          run_acks++;
          chk(int'(src_addr) >= cur_s && int'(src_addr) <= cur_e, "R11 R12 fetch inside latched range", src_addr, cur_s);
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  task automatic prep();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF; cnt[i] = 0; need[i] = 1; drift[i] = 8'h00; srcb[i] = 8'($urandom);
    end
  endtask

  task automatic calc(input int s, input int e, output bit ef, output bit eph,
                      output int ea, output int ep, output int eacks);
    int k;
    ef = 0; eph = 0; ea = 0; ep = 0; eacks = 0;
    for (int a = s; a <= e; a++) begin
      eacks++;
      k = (srcb[a] == 8'hFF) ? 1 : ((need[a] < 1) ? 1 : need[a]);
      if (k > MAXT) begin
        ef = 1; eph = 0; ea = a; ep += MAXT;
        return;
      end
      ep += k;
    end
    for (int a = s; a <= e; a++) begin
      eacks++;
      if (drift[a] != 8'h00) begin
        ef = 1; eph = 1; ea = a;
        return;
      end
    end
  endtask

  task automatic do_run(input int s, input int e, input int late_at, input string tag);
    bit ef, eph; int ea, ep, eacks;
    calc(s, e, ef, eph, ea, ep, eacks);
    @(negedge clk);
    start_addr = AW'(s); end_addr = AW'(e); start = 1;
    cur_s = s; cur_e = e; vpp_cnt = 0; run_pulses = 0; run_acks = 0; first_pulse = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !pass && !fail, {tag, " R10 start clears result"}, {busy, pass, fail}, 4);
    for (int c = 0; busy; c++) begin
      if (c == late_at) begin
        start_addr = 8'h00; end_addr = 8'h7F; start = 1;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk(fail == ef && pass == !ef, {tag, " R6 R9 R10 outcome"}, {pass, fail}, {!ef, ef});
    if (ef) begin
      chk(fail_addr == AW'(ea), {tag, " R6 R9 fail address"}, fail_addr, ea);
      chk(fail_phase == eph, {tag, " R6 R9 fail phase"}, fail_phase, eph);
    end
    chk(run_pulses == ep, {tag, " R5 R7 pulse total"}, run_pulses, ep);
    chk(run_acks == eacks, {tag, " R8 R12 fetch count"}, run_acks, eacks);
    chk(!vpp_hi_en && !vcc_hi_en && mem_ce_n, {tag, " R8 supplies off at end"}, {vpp_hi_en, vcc_hi_en}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, len;
    void'($urandom(32'd7321));
    prep();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !pass && !fail && !src_req, "R1 idle status", {busy, pass, fail, src_req}, 0);
    chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1 strobes high", {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);
    chk(!vcc_hi_en && !vpp_hi_en, "R1 supplies off", {vcc_hi_en, vpp_hi_en}, 0);

    prep(); do_run(8'h10, 8'h17, -1, "basic");
    prep(); need[8'h20] = MAXT; need[8'h21] = MAXT;
    srcb[8'h20] = 8'h5A; srcb[8'h21] = 8'hA5; do_run(8'h20, 8'h22, -1, "limit");
    prep(); need[8'h31] = MAXT + 1; srcb[8'h31] = 8'h3C; do_run(8'h30, 8'h33, -1, "overlimit");
    chk(cnt[8'h31] == MAXT, "R5 R6 pulses at stubborn byte", cnt[8'h31], MAXT);
    prep(); drift[8'h42] = 8'h10; drift[8'h44] = 8'h01; do_run(8'h40, 8'h45, -1, "drift");
    prep(); do_run(8'h50, 8'h53, 20, "busy start");
    chk(cnt[8'h00] == 0 && cnt[8'h7F] == 0, "R11 ignored range untouched", cnt[8'h00], 0);
    prep(); do_run(8'hFF, 8'hFF, -1, "top single");
    prep(); srcb[8'h60] = 8'hFF; need[8'h60] = 40; do_run(8'h60, 8'h61, -1, "erased byte");

    for (int r = 0; r < 8; r++) begin
      prep();
      s = $urandom % 200; len = $urandom % 12;
      for (int a = s; a <= s + len; a++) begin
        need[a] = 1 + $urandom % 4;
        if ($urandom % 10 == 0) need[a] = MAXT + 1;
        if ($urandom % 15 == 0) drift[a] = 8'(1 + $urandom % 255);
      end
      do_run(s, s + len, -1, "random");
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule